// File: doc/BRIEF.md
# Nibble-Serial Chip-Crossing Link

This block is one end of a narrow link between two neighbouring array elements that sit on different chips. Inside each chip, words travel between elements at full width with a valid/ready handshake. Where a neighbour sits on another chip, the word has to cross on four data wires. This block keeps that crossing hidden: the local element still sees an ordinary full-width handshaked port.

One configuration input sets the direction of the link, and it stays fixed while the link runs. In transmit mode the block takes a word from the local element and sends it as eight nibbles on consecutive cycles, least significant nibble first. The first nibble carries a frame-start strobe. The remote receiver returns a level that says whether it has room for a word, and a new word is taken only when that level is high and the previous frame has gone out. In receive mode the block rebuilds the word from the incoming nibbles, offers it on its full-width output and holds it until the local element takes it. While a word is held, the block tells the remote sender that it has no room.

Both ends use the same module, so the same netlist can serve either side of a boundary. The pad drivers and the cabling are outside this block.

Top module: `nib_link`

## Requirements
- R1: In transmit mode (`cfg_tx`=1), a word accepted at a clock edge goes out on `lnk_nib_o` in the next 8 cycles, bits [3:0] first and bits [31:28] last, with `lnk_vld_o` high on all 8 and `lnk_sof_o` high on the first only.
- R2: `in_ready` is high only in transmit mode, when no frame is being sent and `lnk_space_i` is high; a word is accepted at an edge where `in_valid` and `in_ready` are both high.
- R3: Once a word has been accepted, all 8 of its nibbles are sent on back-to-back cycles whatever `lnk_space_i` does, and `in_ready` stays low until the last one has gone out.
- R4: In receive mode (`cfg_tx`=0), a nibble is taken at each edge where `lnk_vld_i` is high. A nibble with `lnk_sof_i` high is the first nibble of a frame. After the eighth nibble of a frame, `out_valid` rises in the next cycle and `out_data` holds the nibbles with the first at bits [3:0].
- R5: A received word stays on `out_data` with `out_valid` high until an edge where `out_ready` is high. `out_valid` is low in the cycle after that edge.
- R6: In receive mode `lnk_space_o` is high exactly when no received word is being held.
- R7: In receive mode, valid nibbles that come before any frame start are dropped. A frame start in the middle of a frame throws away the partial word and begins a new one.
- R8: Nibbles that arrive while a received word is held are dropped. The held word does not change, and no partial frame is carried forward.
- R9: In receive mode, `lnk_nib_o`, `lnk_vld_o` and `lnk_sof_o` stay at 0 and `in_ready` stays low whatever `in_valid` does.
- R10: In transmit mode, `out_valid` and `lnk_space_o` stay low whatever arrives on the link inputs.
- R11: During reset and just after it, no frame is being sent and no word is held: `lnk_vld_o`=0, `out_valid`=0 and `lnk_space_o` = not `cfg_tx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_tx | input | 1 | Link direction: 1 transmit, 0 receive; changed only during reset |
| in_valid | input | 1 | Local word offered for sending |
| in_ready | output | 1 | Local word taken at this edge if valid |
| in_data | input | 32 | Local word to send |
| out_valid | output | 1 | Received word available |
| out_ready | input | 1 | Local element takes the received word |
| out_data | output | 32 | Received word, meaningful while out_valid is high |
| lnk_nib_o | output | 4 | Outgoing nibble |
| lnk_vld_o | output | 1 | Outgoing nibble valid |
| lnk_sof_o | output | 1 | Outgoing nibble is the first of a frame |
| lnk_space_o | output | 1 | Receive side has room for a word |
| lnk_nib_i | input | 4 | Incoming nibble |
| lnk_vld_i | input | 1 | Incoming nibble valid |
| lnk_sof_i | input | 1 | Incoming nibble is the first of a frame |
| lnk_space_i | input | 1 | Remote receiver has room for a word |

## Verification
In transmit mode the link is driven with words whose nibbles are all different, so that a wrong nibble order or a lost nibble shows at once. Words of all ones, all zeros, and the two end bits only are used to catch stuck or swapped end lanes. The space level is held low while a word waits, and it is also pulled low in the middle of a frame: the first shows that the handshake waits for space, the second that a frame in progress is not cut short. In receive mode, frames come back-to-back and also with idle gaps between nibbles, which shows that assembly counts valid nibbles and not cycles. Stray nibbles, a restart in the middle of a frame, and a whole frame sent while a word is held each test a different drop rule. The unused direction's outputs are watched throughout while its inputs are driven.

// File: rtl/nl_pkg.sv
package nl_pkg;
    localparam int unsigned NL_WORD_W = 32;
    localparam int unsigned NL_NIB_W  = 4;

    typedef enum logic {
        NL_DIR_RX = 1'b0,
        NL_DIR_TX = 1'b1
    } nl_dir_e;
endpackage

// File: rtl/nl_ser.sv
module nl_ser #(
    parameter int unsigned WORD_W = nl_pkg::NL_WORD_W,
    parameter int unsigned NIB_W  = nl_pkg::NL_NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              space_i,
    output logic [NIB_W-1:0]  nib_o,
    output logic              vld_o,
    output logic              sof_o
);
    localparam int unsigned NIBS  = WORD_W / NIB_W;
    localparam int unsigned CNT_W = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NIBS - 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  idx;
        logic [WORD_W-1:0] sh;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic    idle_ok;

    assign idle_ok = en & ~st_q.busy & space_i;

    always_comb begin
        st_d = st_q;
        if (idle_ok && in_valid) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.sh   = in_data;
        end else if (st_q.busy) begin
            st_d.sh = st_q.sh >> NIB_W;
            if (st_q.idx == LAST) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = idle_ok;
    assign vld_o    = en & st_q.busy;
    assign sof_o    = en & st_q.busy & (st_q.idx == '0);
    assign nib_o    = (en & st_q.busy) ? st_q.sh[NIB_W-1:0] : '0;
endmodule

// File: rtl/nl_des.sv
module nl_des #(
    parameter int unsigned WORD_W = nl_pkg::NL_WORD_W,
    parameter int unsigned NIB_W  = nl_pkg::NL_NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [NIB_W-1:0]  nib_i,
    input  logic              vld_i,
    input  logic              sof_i,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              space_o
);
    localparam int unsigned NIBS  = WORD_W / NIB_W;
    localparam int unsigned CNT_W = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NIBS - 1);

    typedef struct packed {
        logic              full;
        logic              infr;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
    } des_st_t;

    des_st_t           st_d, st_q;
    logic              take;
    logic [WORD_W-1:0] shifted;

    assign take    = en & vld_i & ~st_q.full;
    assign shifted = {nib_i, st_q.sh[WORD_W-1:NIB_W]};

    always_comb begin
        st_d = st_q;
        if (en && st_q.full && out_ready) begin
            st_d.full = 1'b0;
        end
        if (take) begin
            if (sof_i) begin
                st_d.sh   = shifted;
                st_d.cnt  = CNT_W'(1);
                st_d.infr = 1'b1;
            end else if (st_q.infr) begin
                st_d.sh = shifted;
                if (st_q.cnt == LAST) begin
                    st_d.full = 1'b1;
                    st_d.infr = 1'b0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = en & st_q.full;
    assign out_data  = st_q.sh;
    assign space_o   = en & ~st_q.full;
endmodule

// File: rtl/nib_link.sv
module nib_link #(
    parameter int unsigned WORD_W = nl_pkg::NL_WORD_W,
    parameter int unsigned NIB_W  = nl_pkg::NL_NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [NIB_W-1:0]  lnk_nib_o,
    output logic              lnk_vld_o,
    output logic              lnk_sof_o,
    output logic              lnk_space_o,
    input  logic [NIB_W-1:0]  lnk_nib_i,
    input  logic              lnk_vld_i,
    input  logic              lnk_sof_i,
    input  logic              lnk_space_i
);
    nl_pkg::nl_dir_e dir;
    logic            tx_en;
    logic            rx_en;

    assign dir   = nl_pkg::nl_dir_e'(cfg_tx);
    assign tx_en = (dir == nl_pkg::NL_DIR_TX);
    assign rx_en = (dir == nl_pkg::NL_DIR_RX);

    nl_ser #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .space_i  (lnk_space_i),
        .nib_o    (lnk_nib_o),
        .vld_o    (lnk_vld_o),
        .sof_o    (lnk_sof_o)
    );

    nl_des #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_des (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .nib_i     (lnk_nib_i),
        .vld_i     (lnk_vld_i),
        .sof_i     (lnk_sof_i),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .space_o   (lnk_space_o)
    );
endmodule

// File: rtl/nl_chk.sv
module nl_chk #(
    parameter int unsigned WORD_W = nl_pkg::NL_WORD_W,
    parameter int unsigned NIB_W  = nl_pkg::NL_NIB_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_tx,
    input logic              in_valid,
    input logic              in_ready,
    input logic [WORD_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic [NIB_W-1:0]  lnk_nib_o,
    input logic              lnk_vld_o,
    input logic              lnk_sof_o,
    input logic              lnk_space_o,
    input logic [NIB_W-1:0]  lnk_nib_i,
    input logic              lnk_vld_i,
    input logic              lnk_sof_i,
    input logic              lnk_space_i
);
    // R2: ready only with transmit mode and remote space
    p_ready_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (cfg_tx && lnk_space_i));

    // R1: accepted word starts a frame in the next cycle
    p_accept_sof_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (lnk_vld_o && lnk_sof_o));

    // R3: non-first nibbles always follow a nibble in the previous cycle
    p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_vld_o && !lnk_sof_o) |-> $past(lnk_vld_o));

    // R3: no acceptance while a nibble is on the wire
    p_busy_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_vld_o |-> !in_ready);

    // R5: held word stays put until taken
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6: space is the inverse of a held word in receive mode
    p_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tx |-> (lnk_space_o != out_valid));

    // R9: transmit outputs silent in receive mode
    p_quiet_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tx |-> (!lnk_vld_o && !lnk_sof_o && !in_ready && (lnk_nib_o == '0)));

    // R10: receive outputs silent in transmit mode
    p_quiet_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tx |-> (!out_valid && !lnk_space_o));
endmodule

bind nib_link nl_chk #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_chk (.*);

// File: tb/nib_link_tb_top.sv
`timescale 1ns/1ps
module nib_link_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_tx = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  lnk_nib_o;
    logic        lnk_vld_o;
    logic        lnk_sof_o;
    logic        lnk_space_o;
    logic [3:0]  lnk_nib_i = '0;
    logic        lnk_vld_i = 1'b0;
    logic        lnk_sof_i = 1'b0;
    logic        lnk_space_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nib_link dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_tx(cfg_tx),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .lnk_nib_o(lnk_nib_o), .lnk_vld_o(lnk_vld_o), .lnk_sof_o(lnk_sof_o),
        .lnk_space_o(lnk_space_o), .lnk_nib_i(lnk_nib_i), .lnk_vld_i(lnk_vld_i),
        .lnk_sof_i(lnk_sof_i), .lnk_space_i(lnk_space_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    int          m_k = 0;
    logic [31:0] m_word = '0;
    bit          m_full = 0;
    int          m_cnt = 0;
    logic [31:0] m_acc = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_k <= 0; m_full <= 0; m_cnt <= 0;
        end else if (cfg_tx) begin
            if (m_k == 0) begin
                if (in_valid && lnk_space_i) begin
                    m_k <= 1; m_word <= in_data;
                end
            end else begin
                m_k <= (m_k == 8) ? 0 : m_k + 1;
            end
        end else begin
            if (m_full) begin
                if (out_ready) m_full <= 0;
            end else if (lnk_vld_i) begin
                if (lnk_sof_i) begin
                    m_cnt <= 1; m_acc <= {28'h0, lnk_nib_i};
                end else if (m_cnt > 0) begin
                    m_acc <= m_acc | (32'(lnk_nib_i) << (4 * m_cnt));
                    if (m_cnt == 7) begin m_full <= 1; m_cnt <= 0; end
                    else m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_tx) begin
                chk("R2 in_ready", 32'(in_ready), 32'((m_k == 0) && lnk_space_i));
                chk("R1 lnk_vld_o", 32'(lnk_vld_o), 32'(m_k != 0));
                chk("R1 lnk_sof_o", 32'(lnk_sof_o), 32'(m_k == 1));
                chk("R1 lnk_nib_o", 32'(lnk_nib_o),
                    (m_k != 0) ? ((m_word >> (4 * (m_k - 1))) & 32'hF) : 32'h0);
                chk("R10 out_valid", 32'(out_valid), 32'h0);
                chk("R10 lnk_space_o", 32'(lnk_space_o), 32'h0);
            end else begin
                chk("R9 in_ready", 32'(in_ready), 32'h0);
                chk("R9 lnk_vld_o", 32'(lnk_vld_o), 32'h0);
                chk("R9 lnk_sof_o", 32'(lnk_sof_o), 32'h0);
                chk("R9 lnk_nib_o", 32'(lnk_nib_o), 32'h0);
                chk("R4 out_valid", 32'(out_valid), 32'(m_full));
                chk("R6 lnk_space_o", 32'(lnk_space_o), 32'(!m_full));
                if (m_full) chk("R4 out_data", out_data, m_acc);
            end
        end
    end

    // frames seen on the outgoing pads
    logic [31:0] sent_q[$];
    logic [31:0] got_q[$];
    logic [31:0] cap = '0;
    int          cap_n = 0;
    always @(negedge clk) begin
        if (rst_n && lnk_vld_o) begin
            if (lnk_sof_o) begin
                cap = {28'h0, lnk_nib_o}; cap_n = 1;
            end else begin
                cap = cap | (32'(lnk_nib_o) << (4 * cap_n)); cap_n++;
            end
            if (cap_n == 8) begin got_q.push_back(cap); cap_n = 0; end
        end
    end

    task automatic do_reset(input logic dir);
        @(posedge clk) #1;
        rst_n = 1'b0; cfg_tx = dir;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 lnk_vld_o in reset", 32'(lnk_vld_o), 32'h0);
        chk("R11 out_valid in reset", 32'(out_valid), 32'h0);
        chk("R11 lnk_space_o in reset", 32'(lnk_space_o), 32'(!dir));
        @(posedge clk) #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 lnk_vld_o after reset", 32'(lnk_vld_o), 32'h0);
        chk("R11 out_valid after reset", 32'(out_valid), 32'h0);
    endtask

    task automatic send_word(input logic [31:0] w);
        bit hs;
        @(posedge clk) #1;
        in_valid = 1'b1; in_data = w;
        do begin
            @(negedge clk); hs = in_ready;
            @(posedge clk) #1;
        end while (!hs);
        in_valid = 1'b0;
        sent_q.push_back(w);
    endtask

    task automatic drive_nib(input logic [3:0] n, input logic s);
        @(posedge clk) #1;
        lnk_vld_i = 1'b1; lnk_sof_i = s; lnk_nib_i = n;
        @(posedge clk) #1;
        lnk_vld_i = 1'b0; lnk_sof_i = 1'b0;
    endtask

    task automatic send_frame(input logic [31:0] w, input int gap);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk) #1;
            lnk_vld_i = 1'b1; lnk_sof_i = (i == 0); lnk_nib_i = w[4*i +: 4];
            if (gap > 0) begin
                @(posedge clk) #1;
                lnk_vld_i = 1'b0; lnk_sof_i = 1'b0;
                repeat (gap - 1) @(posedge clk);
            end
        end
        @(posedge clk) #1;
        lnk_vld_i = 1'b0; lnk_sof_i = 1'b0;
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (R1 run incomplete) act=1 exp=0");
        finish_run();
    end

    initial begin
        // ---------------- transmit mode ----------------
        lnk_space_i = 1'b1;
        do_reset(1'b1);
        send_word(32'h7654_3210);
        send_word(32'hFFFF_FFFF);
        send_word(32'h0000_0000);
        send_word(32'h8000_0001);
        // R2: stall with no remote space
        @(posedge clk) #1;
        lnk_space_i = 1'b0; in_valid = 1'b1; in_data = 32'hC3A5_96E1;
        repeat (5) begin
            @(negedge clk);
            chk("R2 in_ready low without space", 32'(in_ready), 32'h0);
        end
        @(posedge clk) #1;
        lnk_space_i = 1'b1;
        in_valid = 1'b0;
        send_word(32'hC3A5_96E1);
        // R3: space dropped mid-frame, frame still completes
        @(posedge clk) #1;
        lnk_space_i = 1'b0;
        repeat (12) @(posedge clk);
        #1 lnk_space_i = 1'b1;
        // R10: garbage on receive pads while transmitting
        @(posedge clk) #1;
        lnk_vld_i = 1'b1; lnk_sof_i = 1'b1; lnk_nib_i = 4'hA;
        repeat (10) @(posedge clk);
        #1 lnk_vld_i = 1'b0; lnk_sof_i = 1'b0;
        send_word(32'h1357_9BDF);
        repeat (12) @(posedge clk);
        @(negedge clk);
        chk("R3 frame count", 32'(got_q.size()), 32'(sent_q.size()));
        for (int i = 0; i < sent_q.size() && i < got_q.size(); i++)
            chk("R1 frame content", got_q[i], sent_q[i]);

        // ---------------- receive mode ----------------
        do_reset(1'b0);
        out_ready = 1'b1;
        send_frame(32'h7654_3210, 0);
        repeat (3) @(posedge clk);
        out_ready = 1'b0;
        send_frame(32'hA5A5_1234, 0);
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R5 held valid", 32'(out_valid), 32'h1);
        chk("R5 held data", out_data, 32'hA5A5_1234);
        // R8: whole frame while full is dropped
        send_frame(32'hDEAD_BEEF, 0);
        @(negedge clk);
        chk("R8 held data unchanged", out_data, 32'hA5A5_1234);
        @(posedge clk) #1 out_ready = 1'b1;
        @(posedge clk) #1 out_ready = 1'b0;
        @(negedge clk);
        chk("R5 released", 32'(out_valid), 32'h0);
        chk("R8 no leftover frame", 32'(lnk_space_o), 32'h1);
        // R7: stray nibbles, then restart mid-frame
        drive_nib(4'h9, 1'b0);
        drive_nib(4'h8, 1'b0);
        drive_nib(4'h7, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7 stray nibbles dropped", 32'(out_valid), 32'h0);
        drive_nib(4'h1, 1'b1);
        drive_nib(4'h2, 1'b0);
        drive_nib(4'h3, 1'b0);
        send_frame(32'h0F1E_2D3C, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R7 restart valid", 32'(out_valid), 32'h1);
        chk("R7 restart data", out_data, 32'h0F1E_2D3C);
        @(posedge clk) #1 out_ready = 1'b1;
        // R4: gaps between nibbles
        send_frame(32'hBADC_0FEE, 2);
        send_frame(32'h8000_0001, 1);
        // R9: local traffic offered while receiving
        @(posedge clk) #1;
        in_valid = 1'b1; in_data = 32'h5555_AAAA;
        repeat (6) @(posedge clk);
        #1 in_valid = 1'b0;
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule